// File: doc/BRIEF.md
# I2C Master Start Reservation Controller

This block holds the start-request logic of an I2C master. When software asks for a start, the block checks whether the bus is currently free. If the bus is free, it drives a one-cycle strobe that tells the line driver to produce a start condition. If the bus is busy, it stores the request as a pending reservation. The reservation fires by itself once the bus is released. A status flag records which of the two paths the request took.

Bus occupancy is tracked from the start and stop detectors. The bus is also treated as released when arbitration ends with the device neither master nor slave, or when software locally releases the bus after an unacknowledged extension code. A down-counter, loaded from a table indexed by the 3-bit clock-mode code, raises a done flag once the settling wait has passed. Software may trust the status flag only after that flag is set. A maskable interrupt reports each detected stop, so that software can start the address transfer once the bus is free.

Top module: `strt_resv_ctrl`

## Requirements
- R1: After synchronous reset, `gen_start`, `master_flag`, `resv_pend`, `bus_busy` and `irq` are 0 and `wait_done` is 1.
- R2: A request (`req_set`=1, `req_clr`=0, no reservation pending) made while `bus_busy`=0 gives `gen_start`=1 for exactly the next cycle, with `master_flag`=1 and `bus_busy`=1 from that cycle on.
- R3: A request made while `bus_busy`=1 gives no `gen_start`. From the next cycle, `resv_pend`=1 and `master_flag`=0.
- R4: While a reservation is pending, the first cycle in which `bus_busy` reads 0 (and `req_clr`=0) is followed by exactly one cycle of `gen_start`=1. In that same cycle `resv_pend` drops to 0 and `master_flag` rises to 1.
- R5: A pulse on `stop_det`, `arb_idle` or `ext_rel` clears `bus_busy` and `master_flag` on the next cycle. A pending reservation then fires as in R4.
- R6: A pulse on `start_det` sets `bus_busy` on the next cycle. When a release input is high in the same cycle, `start_det` takes priority.
- R7: An accepted request loads the wait counter. `wait_done` is then 0 for exactly W cycles and 1 after that. W is selected by `clk_mode`: 0→26, 1→46, 2→92, 3→37, 4→16, 5→32, 6→13, 7→13.
- R8: `req_clr`=1 cancels a pending reservation on the next cycle, and no start follows on a later release. When `req_clr` is high together with `req_set`, the request is dropped.
- R9: A request made while the bus is busy, in the same cycle as `stop_det`, produces exactly one `gen_start` pulse, two cycles after the request.
- R10: `irq` is 1 in the cycle after a cycle with `stop_det`=1 and `stop_ie`=1, and 0 in every other cycle.
- R11: A `req_set` while a reservation is pending is ignored. The wait counter is not reloaded, and the later release still produces exactly one start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_set | input | 1 | Software writes the start-request bit to 1 (one-cycle pulse) |
| req_clr | input | 1 | Software clears the start-request bit (one-cycle pulse) |
| clk_mode | input | 3 | Speed bit and two clock-select bits; selects the wait length |
| stop_ie | input | 1 | Enable for the stop interrupt |
| start_det | input | 1 | Start condition detected on the bus |
| stop_det | input | 1 | Stop condition detected on the bus |
| arb_idle | input | 1 | Arbitration ended with the device neither master nor slave |
| ext_rel | input | 1 | Local release after an extension code with slave operation disabled |
| gen_start | output | 1 | One-cycle strobe: generate a start condition |
| master_flag | output | 1 | 1 = request became a start, 0 = became a reservation |
| resv_pend | output | 1 | A reservation is pending |
| bus_busy | output | 1 | Bus currently in use |
| wait_done | output | 1 | Settling wait after the last accepted request has elapsed |
| irq | output | 1 | Stop interrupt pulse |

## Verification
Every output is registered. A stimulus applied in the cycle before an edge therefore shows on `gen_start`, `resv_pend`, `master_flag`, `bus_busy` and `irq` one cycle later. A reservation freed by a release needs two cycles: one to clear `bus_busy` and one to issue `gen_start`. `wait_done` falls one cycle after acceptance and rises W+1 cycles after it. The bench drives inputs at the falling edge and queues the expected state for the next rising edge. It compares 2 ns after that edge, so every check lands in the cycle its result is due.

// File: rtl/srv_pkg.sv
package srv_pkg;

    localparam int CNT_W  = 7;
    localparam int MODE_W = 3;

    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [MODE_W-1:0] mode_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic arb_idle;
        logic ext_rel;
    } bus_evt_t;

    // Settling wait, in clocks, for each clock-mode code
    function automatic cnt_t wait_len(input mode_t code);
        cnt_t n;
        case (code)
            3'd0:    n = cnt_t'(26);
            3'd1:    n = cnt_t'(46);
            3'd2:    n = cnt_t'(92);
            3'd3:    n = cnt_t'(37);
            3'd4:    n = cnt_t'(16);
            3'd5:    n = cnt_t'(32);
            default: n = cnt_t'(13);
        endcase
        return n;
    endfunction

    function automatic logic is_release(input bus_evt_t e);
        return e.stop | e.arb_idle | e.ext_rel;
    endfunction

endpackage

// File: rtl/srv_bus_track.sv
module srv_bus_track
    import srv_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_evt_t evt,
    input  logic     own_start,
    input  logic     stop_ie,
    output logic     busy,
    output logic     released,
    output logic     irq
);

    assign released = is_release(evt);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            irq  <= 1'b0;
        end else begin
            if (evt.start || own_start)
                busy <= 1'b1;
            else if (released)
                busy <= 1'b0;
            irq <= evt.stop & stop_ie;
        end
    end

    a_r6_start_sets_busy: assert property (@(posedge clk) disable iff (rst)
        evt.start |=> busy);
    a_r5_release_frees: assert property (@(posedge clk) disable iff (rst)
        (released && !evt.start && !own_start) |=> !busy);
    a_r10_irq_follows_stop: assert property (@(posedge clk) disable iff (rst)
        (evt.stop && stop_ie) |=> irq);
    a_r10_irq_quiet: assert property (@(posedge clk) disable iff (rst)
        !(evt.stop && stop_ie) |=> !irq);

endmodule

// File: rtl/srv_wait_timer.sv
module srv_wait_timer
    import srv_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  mode_t mode,
    output logic  done
);

    cnt_t cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= wait_len(mode);
        else if (cnt != '0)
            cnt <= cnt - cnt_t'(1);
    end

    assign done = (cnt == '0);

    a_r7_load_clears_done: assert property (@(posedge clk) disable iff (rst)
        load |=> !done);
    a_r7_done_sticks: assert property (@(posedge clk) disable iff (rst)
        (done && !load) |=> done);

endmodule

// File: rtl/srv_req_arb.sv
module srv_req_arb
    import srv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_set,
    input  logic req_clr,
    input  logic busy,
    input  logic released,
    output logic accept,
    output logic start_nxt,
    output logic gen_start,
    output logic resv_pend,
    output logic master_flag
);

    logic direct, fire, to_resv;

    always_comb begin
        accept    = req_set & ~req_clr & ~resv_pend;
        direct    = accept & ~busy;
        to_resv   = accept & busy;
        fire      = resv_pend & ~busy & ~req_clr;
        start_nxt = direct | fire;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gen_start   <= 1'b0;
            resv_pend   <= 1'b0;
            master_flag <= 1'b0;
        end else begin
            gen_start <= start_nxt;
            if (to_resv)
                resv_pend <= 1'b1;
            else if (fire || req_clr)
                resv_pend <= 1'b0;
            if (start_nxt)
                master_flag <= 1'b1;
            else if (to_resv || released)
                master_flag <= 1'b0;
        end
    end

    a_r2_direct_start: assert property (@(posedge clk) disable iff (rst)
        (accept && !busy) |=> (gen_start && master_flag));
    a_r3_reserve_when_busy: assert property (@(posedge clk) disable iff (rst)
        (accept && busy) |=> (!gen_start && resv_pend && !master_flag));
    a_r4_reservation_fires: assert property (@(posedge clk) disable iff (rst)
        (resv_pend && !busy && !req_clr) |=> (gen_start && !resv_pend));
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
        gen_start |=> !gen_start);
    a_r8_cancel: assert property (@(posedge clk) disable iff (rst)
        req_clr |=> !resv_pend);

endmodule

// File: rtl/strt_resv_ctrl.sv
module strt_resv_ctrl
    import srv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_set,
    input  logic       req_clr,
    input  logic [2:0] clk_mode,
    input  logic       stop_ie,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic       arb_idle,
    input  logic       ext_rel,
    output logic       gen_start,
    output logic       master_flag,
    output logic       resv_pend,
    output logic       bus_busy,
    output logic       wait_done,
    output logic       irq
);

    bus_evt_t evt;
    logic     released, accept, start_nxt;

    assign evt = '{start: start_det, stop: stop_det,
                   arb_idle: arb_idle, ext_rel: ext_rel};

    srv_bus_track u_bus (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .own_start (start_nxt),
        .stop_ie   (stop_ie),
        .busy      (bus_busy),
        .released  (released),
        .irq       (irq)
    );

    srv_req_arb u_arb (
        .clk         (clk),
        .rst         (rst),
        .req_set     (req_set),
        .req_clr     (req_clr),
        .busy        (bus_busy),
        .released    (released),
        .accept      (accept),
        .start_nxt   (start_nxt),
        .gen_start   (gen_start),
        .resv_pend   (resv_pend),
        .master_flag (master_flag)
    );

    srv_wait_timer u_tmr (
        .clk  (clk),
        .rst  (rst),
        .load (accept),
        .mode (mode_t'(clk_mode)),
        .done (wait_done)
    );

    a_r11_no_start_from_busy_resv: assert property (@(posedge clk) disable iff (rst)
        (resv_pend && bus_busy) |=> !gen_start);

endmodule

// File: tb/strt_resv_ctrl_test.sv
module strt_resv_ctrl_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_set = 0, req_clr = 0, stop_ie = 0;
    logic start_det = 0, stop_det = 0, arb_idle = 0, ext_rel = 0;
    logic [2:0] clk_mode = 3'd0;
    logic gen_start, master_flag, resv_pend, bus_busy, wait_done, irq;

    always #4 clk = ~clk;

    strt_resv_ctrl uut (
        .clk(clk), .rst(rst), .req_set(req_set), .req_clr(req_clr),
        .clk_mode(clk_mode), .stop_ie(stop_ie), .start_det(start_det),
        .stop_det(stop_det), .arb_idle(arb_idle), .ext_rel(ext_rel),
        .gen_start(gen_start), .master_flag(master_flag), .resv_pend(resv_pend),
        .bus_busy(bus_busy), .wait_done(wait_done), .irq(irq)
    );

    typedef struct {
        logic [5:0] v;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    int   starts_seen = 0;

    // reference state
    logic m_busy = 0, m_resv = 0, m_master = 0, m_gen = 0, m_irq = 0;
    int   m_cnt = 0;

    function automatic int ref_wait(input logic [2:0] m);
        case (m)
            3'd0: return 26;
            3'd1: return 46;
            3'd2: return 92;
            3'd3: return 37;
            3'd4: return 16;
            3'd5: return 32;
            default: return 13;
        endcase
    endfunction

    function automatic logic [5:0] pack_exp();
        return {m_gen, m_master, m_resv, m_busy, (m_cnt == 0), m_irq};
    endfunction

    task automatic step(input logic rs, input logic rc, input logic sd,
                        input logic pd, input logic ai, input logic er,
                        input logic ie, input logic [2:0] md, input string tag);
        logic rel, acc, fire, nxt;
        exp_t e;
        @(negedge clk);
        req_set = rs; req_clr = rc; start_det = sd; stop_det = pd;
        arb_idle = ai; ext_rel = er; stop_ie = ie; clk_mode = md;
        rel  = pd | ai | er;
        acc  = rs & ~rc & ~m_resv;
        fire = m_resv & ~m_busy & ~rc;
        nxt  = (acc & ~m_busy) | fire;
        if (nxt) m_master = 1;
        else if ((acc & m_busy) || rel) m_master = 0;
        if (acc & m_busy) m_resv = 1;
        else if (fire || rc) m_resv = 0;
        if (acc) m_cnt = ref_wait(md);
        else if (m_cnt > 0) m_cnt--;
        if (sd || nxt) m_busy = 1;
        else if (rel) m_busy = 0;
        m_gen = nxt;
        m_irq = pd & ie;
        e.v = pack_exp();
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0,0,0,0,0,0,stop_ie,clk_mode,tag);
    endtask

    // monitor: compares 2 ns after each rising edge
    always @(posedge clk) begin
        #2;
        if (gen_start) starts_seen++;
        if (exp_q.size() > 0) begin
            exp_t e;
            logic [5:0] act;
            e = exp_q.pop_front();
            act = {gen_start, master_flag, resv_pend, bus_busy, wait_done, irq};
            n_chk++;
            if (act !== e.v) begin
                n_bad++;
                $display("FAIL %s: {gen,mst,resv,busy,wdone,irq} actual=%b expected=%b",
                         e.tag, act, e.v);
            end
        end
    end

    task automatic check_starts(input int expn, input string tag);
        n_chk++;
        if (starts_seen != expn) begin
            n_bad++;
            $display("FAIL %s: start pulses actual=%0d expected=%0d", tag, starts_seen, expn);
        end
        starts_seen = 0;
    endtask

    initial begin
        #(200000 * 8);
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1: reset state, held while idle
        idle(3, "R1");
        starts_seen = 0;
        // R2 + R7: request while bus free, mode 0
        step(1,0,0,0,0,0,1,3'd0, "R2");
        idle(30, "R7");
        // R10 + R5: stop with interrupt enabled frees bus
        step(0,0,0,1,0,0,1,3'd0, "R10");
        idle(2, "R5");
        check_starts(1, "R2");
        // R6 + R3 + R4: external start, request becomes reservation, stop fires it
        step(0,0,1,0,0,0,1,3'd0, "R6");
        step(1,0,0,0,0,0,1,3'd4, "R3");
        idle(5, "R3");
        step(0,0,0,1,0,0,1,3'd4, "R4");
        idle(20, "R4");
        check_starts(1, "R4");
        // R8: cancel a reservation
        step(0,0,0,1,0,0,1,3'd4, "R8");
        step(0,0,1,0,0,0,1,3'd4, "R8");
        step(1,0,0,0,0,0,1,3'd6, "R8");
        step(0,1,0,0,0,0,1,3'd6, "R8");
        step(0,0,0,1,0,0,1,3'd6, "R8");
        idle(15, "R8");
        // R8: set and clear together is dropped
        step(1,1,0,0,0,0,1,3'd6, "R8");
        idle(3, "R8");
        check_starts(0, "R8");
        // R9: request and stop in the same cycle while busy
        step(0,0,1,0,0,0,1,3'd6, "R9");
        step(1,0,0,1,0,0,1,3'd6, "R9");
        idle(16, "R9");
        check_starts(1, "R9");
        // R11: second request during reservation ignored
        step(0,0,0,1,0,0,1,3'd6, "R11");
        step(0,0,1,0,0,0,1,3'd6, "R11");
        step(1,0,0,0,0,0,1,3'd0, "R11");
        idle(4, "R11");
        step(1,0,0,0,0,0,1,3'd2, "R11");
        idle(4, "R11");
        step(0,0,0,0,1,0,1,3'd2, "R5");
        idle(25, "R11");
        check_starts(1, "R11");
        // R5: local release frees the bus; reservation fires
        step(0,0,0,0,1,0,1,3'd2, "R5");
        step(0,0,1,0,0,0,1,3'd2, "R5");
        step(1,0,0,0,0,0,1,3'd5, "R5");
        step(0,0,0,0,0,1,1,3'd5, "R5");
        idle(35, "R5");
        check_starts(1, "R5");
        // R6: start and release in the same cycle keep bus busy
        step(0,0,1,1,0,0,1,3'd5, "R6");
        step(0,0,0,1,0,0,1,3'd5, "R6");
        // R10: stop with interrupt disabled
        step(0,0,0,1,0,0,0,3'd5, "R10");
        idle(2, "R10");
        // R7: every mode from a free bus
        for (int m = 0; m < 8; m++) begin
            step(1,0,0,0,0,0,0,3'(m), "R7");
            idle(ref_wait(3'(m)) + 2, "R7");
            step(0,0,0,1,0,0,0,3'(m), "R7");
        end
        idle(2, "R7");
        check_starts(8, "R7");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule